// File: doc/BRIEF.md
# Byte-Serial BCH Parity Encoder for NAND Sectors

This block computes the 104-bit parity of a binary BCH code that corrects up to eight bit errors per NAND sector. The code works over GF(2^13) built on the primitive polynomial x^13+x^4+x^3+x+1, and 13 parity bits are needed for each correctable error. A flash programmer or controller streams the raw sector through the block and appends the resulting 13 parity bytes to the spare area. The encoder divides the message by a fixed degree-104 generator in the same way as a very wide CRC. It starts from zero and applies no inversion at either end.

Data enters one byte per cycle on a byte port or one 32-bit word per cycle on an optional word port. A `start` pulse opens a sector and the caller marks the final beat with a last flag. Each byte passes through an unrolled parallel LFSR with no lookup table. When the sector ends, the parity appears as a big-endian word, as a byte-reversed register view and as a 13-byte stream with a valid/ready handshake. The inputs are held off while that stream drains.

Top module: `bch8_enc`

## Requirements
- R1: After reset, `in_ready` is 1, `parity_valid` and `ser_valid` are 0, and `parity_be` is zero.
- R2: `parity_be` equals M(x)·x^104 mod g(x), where g(x) = x^104 + 0x15f914e07b0c138741c5c4fb23 and M(x) is the message with each byte taken most significant bit first. The initial value is zero and there is no inversion. A sector whose only set bit is bit 0 of its final byte therefore gives exactly 0x15f914e07b0c138741c5c4fb23.
- R3: A `start` seen while `in_ready` is 1 discards the previous remainder. A byte or word accepted in that same cycle is folded into a zero remainder.
- R4: An accepted word is absorbed in one cycle as four bytes in the order `word_data[7:0]`, `[15:8]`, `[23:16]`, `[31:24]`. This gives the same parity as sending those bytes on the byte port. The two ports are never valid in the same cycle.
- R5: `parity_valid` is high for exactly one cycle: the cycle after the beat that carries the last flag is accepted.
- R6: `parity_le` is the byte reverse of `parity_be`. Bits 7:0 of `parity_le` hold bits 103:96 of `parity_be`, and bits 103:96 of `parity_le` hold bits 7:0 of `parity_be`.
- R7: After a sector ends, `ser_valid` presents 13 bytes, starting in the same cycle as `parity_valid`. The first byte is `parity_be[103:96]` and the last is `parity_be[7:0]`. A byte moves on only when `ser_ready` is 1, and it holds steady while `ser_ready` is 0. `ser_valid` falls after the 13th transfer.
- R8: While the parity stream is pending, `in_ready` is 0. During that time `start` and both data ports are ignored and the parity outputs do not change.
- R9: A sector made entirely of zero bytes gives zero parity.
- R10: The parity is XOR-linear: parity(A xor B) equals parity(A) xor parity(B) for sectors of equal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears the remainder; marks the first beat of a sector |
| byte_valid | input | 1 | Byte port beat valid |
| byte_data | input | 8 | Data byte |
| byte_last | input | 1 | Final beat of the sector on the byte port |
| word_valid | input | 1 | Word port beat valid |
| word_data | input | 32 | Data word; bits 7:0 are absorbed first |
| word_last | input | 1 | Final beat of the sector on the word port |
| in_ready | output | 1 | Input beats and `start` are accepted |
| parity_valid | output | 1 | One-cycle pulse when the sector parity is ready |
| parity_be | output | 104 | Remainder, bit 103 is the most significant |
| parity_le | output | 104 | Byte-reversed view of the remainder |
| ser_valid | output | 1 | Serial parity byte valid |
| ser_ready | input | 1 | Downstream accepts the serial byte |
| ser_data | output | 8 | Serial parity byte, most significant first |

## Verification
The assertions assume that the byte and word ports are never valid together, and that the last flag only comes with a valid beat. The assertion on the zero-feedback shift assumes that `start` is not present on that beat. The bench drives exactly one port per sector and raises `start` only on a sector's first beat. It changes inputs only at falling edges, and its only out-of-protocol stimulus is a `start` and a byte pulsed into the block while the parity stream is pending. Random sectors, the byte order on the word port and random backpressure on the serial side are all checked against a bit-serial long division computed in the bench.

// File: rtl/bch8_pkg.sv
package bch8_pkg;
  localparam int BCH_M = 13;
  localparam int BCH_T = 8;
  localparam int PAR_W_DEF = BCH_M * BCH_T;
  localparam logic [PAR_W_DEF-1:0] GEN_DEF = 104'h15f914e07b0c138741c5c4fb23;
  localparam int WORD_BYTES_DEF = 4;

  typedef enum logic {SO_IDLE, SO_SEND} so_state_t;
endpackage

// File: rtl/bch8_byte_step.sv
module bch8_byte_step #(
  parameter int PAR_W = bch8_pkg::PAR_W_DEF,
  parameter logic [PAR_W-1:0] GEN = bch8_pkg::GEN_DEF
) (
  input  logic [PAR_W-1:0] rem_i,
  input  logic [7:0]       byte_i,
  output logic [PAR_W-1:0] rem_o
);
  // one division step: multiply by x, add the incoming bit, reduce by g
  function automatic logic [PAR_W-1:0] div_bit(input logic [PAR_W-1:0] r, input logic b);
    logic fb;
    fb = r[PAR_W-1] ^ b;
    div_bit = {r[PAR_W-2:0], 1'b0} ^ (fb ? GEN : '0);
  endfunction

  function automatic logic [PAR_W-1:0] div_byte(input logic [PAR_W-1:0] r, input logic [7:0] b);
    logic [PAR_W-1:0] acc;
    acc = r;
    for (int i = 7; i >= 0; i--) acc = div_bit(acc, b[i]);
    div_byte = acc;
  endfunction

  always_comb rem_o = div_byte(rem_i, byte_i);
endmodule

// File: rtl/bch8_lane_chain.sv
module bch8_lane_chain #(
  parameter int PAR_W = bch8_pkg::PAR_W_DEF,
  parameter logic [PAR_W-1:0] GEN = bch8_pkg::GEN_DEF,
  parameter int LANES = bch8_pkg::WORD_BYTES_DEF
) (
  input  logic [PAR_W-1:0]            rem_i,
  input  logic [LANES*8-1:0]          data_i,
  output logic [LANES-1:0][PAR_W-1:0] stage_o
);
  logic [LANES:0][PAR_W-1:0] chain;
  assign chain[0] = rem_i;

  // lane g consumes data_i byte g after lanes 0..g-1
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bch8_byte_step #(.PAR_W(PAR_W), .GEN(GEN)) u_step (
      .rem_i (chain[g]),
      .byte_i(data_i[g*8 +: 8]),
      .rem_o (chain[g+1])
    );
    assign stage_o[g] = chain[g+1];
  end
endmodule

// File: rtl/bch8_stream_out.sv
module bch8_stream_out #(
  parameter int PAR_W = bch8_pkg::PAR_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PAR_W-1:0] par_i,
  output logic             idle_o,
  output logic             ser_valid,
  input  logic             ser_ready,
  output logic [7:0]       ser_data
);
  import bch8_pkg::*;
  localparam int PAR_BYTES = PAR_W / 8;
  localparam int IDX_W = $clog2(PAR_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAR_BYTES - 1);

  so_state_t state_q;
  logic [IDX_W-1:0] idx_q;
  logic xfer, xfer_last;

  assign idle_o    = (state_q == SO_IDLE);
  assign ser_valid = (state_q == SO_SEND);
  assign xfer      = ser_valid && ser_ready;
  assign xfer_last = xfer && (idx_q == IDX_LAST);

  // byte idx counts from the most significant end of the remainder
  always_comb begin
    ser_data = '0;
    for (int b = 0; b < PAR_BYTES; b++)
      if (idx_q == IDX_W'(b)) ser_data = par_i[PAR_W-8*(b+1) +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SO_IDLE;
      idx_q   <= '0;
    end else if (load) begin
      state_q <= SO_SEND;
      idx_q   <= '0;
    end else if (xfer_last) begin
      state_q <= SO_IDLE;
      idx_q   <= '0;
    end else if (xfer) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid && !ser_ready |=> ser_valid && $stable(ser_data));
  assert_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_last |=> !ser_valid);
  assert_idle_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> idle_o);
endmodule

// File: rtl/bch8_enc.sv
module bch8_enc #(
  parameter int PAR_W = bch8_pkg::PAR_W_DEF,
  parameter logic [PAR_W-1:0] GEN = bch8_pkg::GEN_DEF,
  parameter int WORD_BYTES = bch8_pkg::WORD_BYTES_DEF,
  parameter bit WORD_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    byte_valid,
  input  logic [7:0]              byte_data,
  input  logic                    byte_last,
  input  logic                    word_valid,
  input  logic [WORD_BYTES*8-1:0] word_data,
  input  logic                    word_last,
  output logic                    in_ready,
  output logic                    parity_valid,
  output logic [PAR_W-1:0]        parity_be,
  output logic [PAR_W-1:0]        parity_le,
  output logic                    ser_valid,
  input  logic                    ser_ready,
  output logic [7:0]              ser_data
);
  localparam int PAR_BYTES = PAR_W / 8;
  localparam int LANES = WORD_EN ? WORD_BYTES : 1;

  logic [PAR_W-1:0] rem_q, rem_base, rem_d;
  logic [LANES*8-1:0] lane_data;
  logic [LANES-1:0][PAR_W-1:0] stage;
  logic byte_fire, word_fire, accept, start_ok, take_last, pv_q;

  assign byte_fire = byte_valid && in_ready;
  assign word_fire = WORD_EN && word_valid && in_ready;
  assign accept    = byte_fire || word_fire;
  assign start_ok  = start && in_ready;
  assign take_last = (byte_fire && byte_last) || (word_fire && word_last);
  assign rem_base  = start_ok ? '0 : rem_q;

  if (LANES > 1) begin : g_word
    assign lane_data = word_fire ? word_data[LANES*8-1:0]
                                 : {{(LANES*8-8){1'b0}}, byte_data};
  end else begin : g_byte_only
    assign lane_data = byte_data;
  end

  bch8_lane_chain #(.PAR_W(PAR_W), .GEN(GEN), .LANES(LANES)) u_chain (
    .rem_i  (rem_base),
    .data_i (lane_data),
    .stage_o(stage)
  );

  assign rem_d = word_fire ? stage[LANES-1] : stage[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      pv_q  <= 1'b0;
    end else begin
      pv_q <= take_last;
      if (accept)        rem_q <= rem_d;
      else if (start_ok) rem_q <= '0;
    end
  end

  assign parity_valid = pv_q;
  assign parity_be    = rem_q;

  for (genvar b = 0; b < PAR_BYTES; b++) begin : g_le
    assign parity_le[8*b +: 8] = rem_q[PAR_W-8*(b+1) +: 8];
  end

  bch8_stream_out #(.PAR_W(PAR_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take_last),
    .par_i    (rem_q),
    .idle_o   (in_ready),
    .ser_valid(ser_valid),
    .ser_ready(ser_ready),
    .ser_data (ser_data)
  );

  assert_zero_fb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fire && !start && !word_valid && ((byte_data ^ rem_q[PAR_W-1 -: 8]) == 8'h00)
    |=> rem_q == ($past(rem_q) << 8));
  assert_start_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start && in_ready && !byte_valid && !word_valid |=> parity_be == '0);
  assert_one_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && word_valid));
  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    parity_valid |=> !parity_valid);
  assert_hold_rem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(rem_q));
  assert_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fire && !word_valid && rem_q == '0 && byte_data == 8'h00 |=> rem_q == '0);
endmodule

// File: tb/sim_bch8_enc.sv
module sim_bch8_enc;
  localparam logic [103:0] G_LOW = 104'h15f914e07b0c138741c5c4fb23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, byte_valid = 0, byte_last = 0, word_valid = 0, word_last = 0, ser_ready = 0;
  logic [7:0] byte_data = 0;
  logic [31:0] word_data = 0;
  logic in_ready, parity_valid, ser_valid;
  logic [103:0] parity_be, parity_le;
  logic [7:0] ser_data;

  int nchecks = 0;
  int nerr = 0;
  bit done = 0;
  logic [7:0] msg [0:511];
  logic [7:0] ma [0:511];
  logic [7:0] mb [0:511];
  logic [103:0] got, pa, pb;

  always #10 clk = ~clk;

  bch8_enc u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_last(byte_last),
    .word_valid(word_valid), .word_data(word_data), .word_last(word_last),
    .in_ready(in_ready), .parity_valid(parity_valid),
    .parity_be(parity_be), .parity_le(parity_le),
    .ser_valid(ser_valid), .ser_ready(ser_ready), .ser_data(ser_data)
  );

  task automatic check(input bit ok, input string req, input logic [103:0] act, input logic [103:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // long division of the bit stream, then 104 zero bits flushed through
  function automatic logic [103:0] ref_parity(input int len);
    logic [103:0] r;
    logic top;
    r = '0;
    for (int i = 0; i < len; i++)
      for (int k = 7; k >= 0; k--) begin
        top = r[103];
        r = {r[102:0], msg[i][k]};
        if (top) r = r ^ G_LOW;
      end
    for (int z = 0; z < 104; z++) begin
      top = r[103];
      r = {r[102:0], 1'b0};
      if (top) r = r ^ G_LOW;
    end
    return r;
  endfunction

  function automatic logic [103:0] flip_bytes(input logic [103:0] v);
    logic [103:0] o;
    for (int b = 0; b < 13; b++) o[8*b +: 8] = v[103-8*b -: 8];
    return o;
  endfunction

  task automatic run_sector(input int len, input bit use_word, input bit inject,
                            input logic [103:0] exp, input string tag);
    int idx, cyc;
    bit pv, pr, r;
    logic [7:0] pd;
    if (use_word) begin
      for (int w = 0; w < len / 4; w++) begin
        @(negedge clk);
        start = (w == 0);
        word_valid = 1'b1;
        word_data = {msg[4*w+3], msg[4*w+2], msg[4*w+1], msg[4*w]};
        word_last = (w == len / 4 - 1);
      end
    end else begin
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        start = (i == 0);
        byte_valid = 1'b1;
        byte_data = msg[i];
        byte_last = (i == len - 1);
      end
    end
    @(negedge clk);
    start = 0; byte_valid = 0; byte_last = 0; word_valid = 0; word_last = 0;
    check(parity_valid == 1'b1, "R5 parity_valid pulse", {103'd0, parity_valid}, 104'd1);
    got = parity_be;
    check(parity_be == exp, tag, parity_be, exp);
    check(parity_le == flip_bytes(exp), "R6 byte-reversed view", parity_le, flip_bytes(exp));
    idx = 0; cyc = 0; pv = 0; pr = 0; pd = 0;
    while (idx < 13 && cyc < 400) begin
      if (cyc == 1) check(parity_valid == 1'b0, "R5 single cycle", {103'd0, parity_valid}, 104'd0);
      if (pv && !pr) check(ser_valid && ser_data == pd, "R7 held under backpressure",
                           {95'd0, ser_valid, ser_data}, {95'd0, 1'b1, pd});
      if (inject && cyc == 2) begin
        check(in_ready == 1'b0, "R8 in_ready low while streaming", {103'd0, in_ready}, 104'd0);
        start = 1; byte_valid = 1; byte_data = 8'hA5; byte_last = 1;
      end else begin
        start = 0; byte_valid = 0; byte_last = 0;
      end
      r = ($urandom % 3) != 0;
      ser_ready = r;
      if (ser_valid && r) begin
        check(ser_data == exp[103-8*idx -: 8], "R7 serial byte order",
              {96'd0, ser_data}, {96'd0, exp[103-8*idx -: 8]});
        idx++;
      end
      pv = ser_valid; pr = r; pd = ser_data;
      @(negedge clk);
      cyc++;
    end
    ser_ready = 0; start = 0; byte_valid = 0; byte_last = 0;
    check(idx == 13 && ser_valid == 1'b0 && in_ready == 1'b1, "R7 R8 stream ends, input reopens",
          {95'd0, ser_valid, in_ready, 4'(idx), 3'd0}, {95'd0, 1'b0, 1'b1, 4'd13, 3'd0});
    if (inject) check(parity_be == exp && parity_valid == 1'b0, "R8 injected beat ignored", parity_be, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchecks++; nerr++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  initial begin
    logic [103:0] e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && parity_valid == 1'b0 && ser_valid == 1'b0,
          "R1 reset handshake state", {101'd0, in_ready, parity_valid, ser_valid}, 104'd4);
    check(parity_be == '0, "R1 reset remainder", parity_be, '0);

    // all-zero sector
    for (int i = 0; i < 512; i++) msg[i] = 8'h00;
    run_sector(512, 0, 0, 104'd0, "R9 zero sector");

    // single bit at the very end: parity is the generator's low part
    msg[511] = 8'h01;
    run_sector(512, 0, 0, G_LOW, "R2 single low bit gives generator");

    // single bit at the front, word port
    msg[511] = 8'h00; msg[0] = 8'h80;
    run_sector(512, 1, 0, ref_parity(512), "R4 single high bit word port");

    // random sectors, byte and word port, with an injected beat while streaming
    for (int i = 0; i < 512; i++) msg[i] = 8'($urandom);
    run_sector(512, 0, 1, ref_parity(512), "R2 random sector byte port");
    for (int i = 0; i < 512; i++) msg[i] = 8'($urandom);
    run_sector(512, 1, 0, ref_parity(512), "R4 random sector word port");

    // short sector right after a non-zero one: start must clear the remainder
    for (int i = 0; i < 13; i++) msg[i] = 8'($urandom);
    run_sector(13, 0, 0, ref_parity(13), "R3 start clears prior remainder");

    // linearity
    for (int i = 0; i < 512; i++) begin ma[i] = 8'($urandom); mb[i] = 8'($urandom); end
    for (int i = 0; i < 512; i++) msg[i] = ma[i];
    run_sector(512, 0, 0, ref_parity(512), "R2 linearity operand A");
    pa = got;
    for (int i = 0; i < 512; i++) msg[i] = mb[i];
    run_sector(512, 1, 0, ref_parity(512), "R4 linearity operand B");
    pb = got;
    for (int i = 0; i < 512; i++) msg[i] = ma[i] ^ mb[i];
    e = ref_parity(512);
    run_sector(512, 0, 0, e, "R2 linearity xor sector");
    check(got == (pa ^ pb), "R10 parity(A^B) = parity(A)^parity(B)", got, pa ^ pb);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule